// File: doc/BRIEF.md
# Accumulator Extended Shift Unit

This block keeps a 12-bit accumulator together with an 11-bit extension register that no other datapath can see. A single start strobe runs one of four operations: a multi-cycle left shift, a multi-cycle right shift, a copy from the accumulator into the extension, or a copy from the extension into the accumulator. Each shift cycle moves the pair by exactly one bit position and trades one bit between the two registers. A right shift also repeats the accumulator's sign bit, so the unit gives an arithmetic shift over the combined register pair.

A host sequencer loads the accumulator through a parallel load path. It starts an operation with a 4-bit shift count. It waits for the done pulse and then reads both registers from the output ports. A right shift that follows a load forms a signed value across the pair, with the bits shifted out of the accumulator collected in the extension. The `ext_q` output acts as a store port for the extension.

Top module: `acc_ext_shift_unit`

## Requirements
- R1: After reset, `acc_q` is 0, `ext_q` is 0, `busy` is 0 and `done` is 0.
- R2: A cycle with `load_en` high, `start` low and `busy` low writes `load_data` into the accumulator at that clock edge and leaves the extension unchanged.
- R3: `op`=0 selects the left shift. On each shift cycle the accumulator moves up one place and drops bit 11, accumulator bit 0 takes extension bit 10, and the extension moves up one place with 0 entering bit 0.
- R4: `op`=1 selects the right shift. On each shift cycle the extension moves down one place and loses bit 0, accumulator bit 0 goes into extension bit 10, and the accumulator moves down one place with bit 11 kept and copied into bit 10.
- R5: A shift started with `count`=N, where N is 1 to 15, holds `busy` high for exactly N cycles, starting the cycle after the start edge, and performs N shift cycles. `done` is high for one cycle, in the cycle right after `busy` falls. In that cycle both registers already hold their final values.
- R6: A shift started with `count`=0 never raises `busy`, changes neither register, and raises `done` for one cycle right after the start edge.
- R7: `op`=2 copies accumulator bits 10..0 into the extension at the start edge and leaves the accumulator unchanged. `done` is high for the following cycle.
- R8: `op`=3 copies the extension into the accumulator, zero-extended so that accumulator bit 11 is 0, at the start edge and leaves the extension unchanged. `done` is high for the following cycle.
- R9: While `busy` is high, `start` and `load_en` have no effect. The operation in progress finishes with the result it would have without them, and it produces exactly one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts the operation in `op` when the unit is idle |
| op | input | 2 | 0 left shift, 1 right shift, 2 accumulator to extension, 3 extension to accumulator |
| count | input | 4 | Shift count for operations 0 and 1 |
| load_en | input | 1 | Parallel load request for the accumulator |
| load_data | input | 12 | Value to load into the accumulator |
| acc_q | output | 12 | Accumulator value |
| ext_q | output | 11 | Extension register value (store port) |
| busy | output | 1 | High while shift cycles remain |
| done | output | 1 | One-cycle completion pulse |

## Verification
A move or a zero-count shift shows its result, with `done` high, one cycle after the start edge. A shift of N shows `busy` for the N cycles that follow the start edge and `done` with the final registers in cycle N+1. The driver raises strobes on falling edges and counts `busy` samples on falling edges against N. At each issue it pushes the expected register pair, computed with a whole-pair arithmetic or logical shift model, into a queue. The monitor pops that entry on the falling edge where `done` is high, so every comparison happens in the cycle when the result is due. Any `done` pulse with no queued entry is reported as a failure.

// File: rtl/acc_ext_shift_pkg.sv
package acc_ext_shift_pkg;

  typedef enum logic [1:0] {
    OP_SHL = 2'd0,
    OP_SHR = 2'd1,
    OP_A2E = 2'd2,
    OP_E2A = 2'd3
  } shift_op_e;

  function automatic logic op_is_shift(input shift_op_e o);
    return (o == OP_SHL) || (o == OP_SHR);
  endfunction

endpackage

// File: rtl/aes_sequencer.sv
module aes_sequencer
  import acc_ext_shift_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [CNT_W-1:0] count,
  input  logic             load_en,
  output logic             shl_en,
  output logic             shr_en,
  output logic             a2e_en,
  output logic             e2a_en,
  output logic             load_ok,
  output logic             busy,
  output logic             done
);

  shift_op_e        op_in;
  shift_op_e        op_q;
  logic [CNT_W-1:0] left_q;
  logic             busy_q;
  logic             done_q;
  logic             accept;
  logic             last_step;
  logic             long_shift;

  assign op_in      = shift_op_e'(op);
  assign accept     = start && !busy_q;
  assign long_shift = op_is_shift(op_in) && (count != '0);
  assign last_step  = busy_q && (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_SHL;
      left_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q <= op_in;
        if (long_shift) begin
          busy_q <= 1'b1;
          left_q <= count;
        end else begin
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        left_q <= left_q - CNT_W'(1);
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign shl_en  = busy_q && (op_q == OP_SHL);
  assign shr_en  = busy_q && (op_q == OP_SHR);
  assign a2e_en  = accept && (op_in == OP_A2E);
  assign e2a_en  = accept && (op_in == OP_E2A);
  assign load_ok = load_en && !busy_q && !start;
  assign busy    = busy_q;
  assign done    = done_q;

  // R5: the remaining-step counter is never zero while busy
  a_r5_busy_has_steps: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (left_q != '0));

  // R5: the falling edge of busy is followed by the done pulse
  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R5: done is a single-cycle pulse while the unit is idle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);

  // R9: a start seen while busy does not change the latched operation
  a_r9_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_step) |=> $stable(op_q) && busy_q);

  // R6: a zero-count shift never raises busy
  a_r6_zero_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_is_shift(op_in) && (count == '0)) |=> (!busy_q && done_q));

endmodule

// File: rtl/aes_datapath.sv
module aes_datapath #(
  parameter int ACC_W = 12,
  parameter int EXT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shl_en,
  input  logic             shr_en,
  input  logic             a2e_en,
  input  logic             e2a_en,
  input  logic             load_ok,
  input  logic [ACC_W-1:0] load_data,
  output logic [ACC_W-1:0] acc_q,
  output logic [EXT_W-1:0] ext_q
);

  localparam int PAIR_W = ACC_W + EXT_W;
  localparam int PAD_W  = ACC_W - EXT_W;

  function automatic logic [PAIR_W-1:0] step_left(input logic [ACC_W-1:0] a,
                                                   input logic [EXT_W-1:0] e);
    logic [ACC_W-1:0] na;
    logic [EXT_W-1:0] ne;
    na = {a[ACC_W-2:0], e[EXT_W-1]};
    ne = {e[EXT_W-2:0], 1'b0};
    return {na, ne};
  endfunction

  function automatic logic [PAIR_W-1:0] step_right(input logic [ACC_W-1:0] a,
                                                    input logic [EXT_W-1:0] e);
    logic [ACC_W-1:0] na;
    logic [EXT_W-1:0] ne;
    ne = {a[0], e[EXT_W-1:1]};
    na = {a[ACC_W-1], a[ACC_W-1:1]};
    return {na, ne};
  endfunction

  logic [PAIR_W-1:0] left_pair;
  logic [PAIR_W-1:0] right_pair;
  logic              any_en;

  assign left_pair  = step_left(acc_q, ext_q);
  assign right_pair = step_right(acc_q, ext_q);
  assign any_en     = shl_en | shr_en | a2e_en | e2a_en | load_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ext_q <= '0;
    end else if (shl_en) begin
      acc_q <= left_pair[PAIR_W-1:EXT_W];
      ext_q <= left_pair[EXT_W-1:0];
    end else if (shr_en) begin
      acc_q <= right_pair[PAIR_W-1:EXT_W];
      ext_q <= right_pair[EXT_W-1:0];
    end else if (a2e_en) begin
      ext_q <= acc_q[EXT_W-1:0];
    end else if (e2a_en) begin
      acc_q <= {{PAD_W{1'b0}}, ext_q};
    end else if (load_ok) begin
      acc_q <= load_data;
    end
  end

  // R9: with no enable from the sequencer both registers hold
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !any_en |=> ($stable(acc_q) && $stable(ext_q)));

  // R3: a left step always clears extension bit 0
  a_r3_ext_lsb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    shl_en |=> (ext_q[0] == 1'b0));

  // R4: a right step keeps the accumulator sign
  a_r4_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    shr_en |=> (acc_q[ACC_W-1] == $past(acc_q[ACC_W-1])));

  // R8: moving the extension up leaves the top accumulator bit clear
  a_r8_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    e2a_en |=> ((acc_q[ACC_W-1] == 1'b0) && $stable(ext_q)));

  // R7: moving the accumulator down leaves the accumulator unchanged
  a_r7_acc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    a2e_en |=> $stable(acc_q));

  // enables from the sequencer never overlap
  a_r9_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shl_en, shr_en, a2e_en, e2a_en, load_ok}));

endmodule

// File: rtl/acc_ext_shift_unit.sv
module acc_ext_shift_unit #(
  parameter int ACC_W = 12,
  parameter int EXT_W = 11,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [CNT_W-1:0] count,
  input  logic             load_en,
  input  logic [ACC_W-1:0] load_data,
  output logic [ACC_W-1:0] acc_q,
  output logic [EXT_W-1:0] ext_q,
  output logic             busy,
  output logic             done
);

  logic shl_en;
  logic shr_en;
  logic a2e_en;
  logic e2a_en;
  logic load_ok;

  aes_sequencer #(.CNT_W(CNT_W)) seq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .count   (count),
    .load_en (load_en),
    .shl_en  (shl_en),
    .shr_en  (shr_en),
    .a2e_en  (a2e_en),
    .e2a_en  (e2a_en),
    .load_ok (load_ok),
    .busy    (busy),
    .done    (done)
  );

  aes_datapath #(.ACC_W(ACC_W), .EXT_W(EXT_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .shl_en    (shl_en),
    .shr_en    (shr_en),
    .a2e_en    (a2e_en),
    .e2a_en    (e2a_en),
    .load_ok   (load_ok),
    .load_data (load_data),
    .acc_q     (acc_q),
    .ext_q     (ext_q)
  );

  // R2: an accepted load appears on the accumulator one cycle later
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !start && !busy) |=> ((acc_q == $past(load_data)) && $stable(ext_q)));

endmodule

// File: tb/acc_ext_shift_unit_tb_top.sv
module acc_ext_shift_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [3:0]  count = 4'd0;
  logic        load_en = 1'b0;
  logic [11:0] load_data = 12'd0;
  logic [11:0] acc_q;
  logic [10:0] ext_q;
  logic        busy;
  logic        done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [22:0] m_pair = 23'd0;
  logic [22:0] exp_q[$];

  always #4 clk = ~clk;

  acc_ext_shift_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .count(count),
    .load_en(load_en), .load_data(load_data), .acc_q(acc_q), .ext_q(ext_q),
    .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // reference: the register pair treated as one 23-bit word
  function automatic logic [22:0] model(input logic [22:0] v, input logic [1:0] o,
                                        input logic [3:0] n);
    logic signed [22:0] s;
    s = v;
    case (o)
      2'd0: for (int i = 0; i < n; i++) s = s <<< 1;
      2'd1: for (int i = 0; i < n; i++) s = s >>> 1;
      2'd2: s = {v[22:11], v[21:11]};
      default: s = {1'b0, v[10:0], v[10:0]};
    endcase
    return s;
  endfunction

  // monitor: compares each completion with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R9 actual=unexpected_done expected=no_done");
      end else begin
        logic [22:0] e;
        e = exp_q.pop_front();
        check("R3/R4/R6/R7/R8 pair", {9'd0, acc_q, ext_q}, {9'd0, e});
        check("R5 busy low at done", {31'd0, busy}, 32'd0);
      end
    end
  end

  task automatic do_load(input logic [11:0] v);
    @(negedge clk);
    load_en = 1'b1;
    load_data = v;
    @(negedge clk);
    load_en = 1'b0;
    m_pair = {v, m_pair[10:0]};
    check("R2 load acc", {20'd0, acc_q}, {20'd0, v});
    check("R2 load ext", {21'd0, ext_q}, {21'd0, m_pair[10:0]});
  endtask

  task automatic run_op(input logic [1:0] o, input logic [3:0] n, input bit inject);
    int nbusy;
    int expb;
    nbusy = 0;
    expb = (o <= 2'd1) ? int'(n) : 0;
    m_pair = model(m_pair, o, n);
    exp_q.push_back(m_pair);
    @(negedge clk);
    start = 1'b1;
    op = o;
    count = n;
    @(negedge clk);
    start = 1'b0;
    while (busy && nbusy < 40) begin
      nbusy++;
      if (inject && nbusy == 2) begin
        start = 1'b1;
        op = 2'd3;
        count = 4'd9;
        load_en = 1'b1;
        load_data = 12'h5A5;
      end else begin
        start = 1'b0;
        load_en = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    load_en = 1'b0;
    check(o <= 2'd1 ? (n == 0 ? "R6 busy cycles" : "R5 busy cycles") : "R7/R8 busy cycles",
          nbusy, expb);
    @(negedge clk);
    check("R5 single done", {31'd0, done}, 32'd0);
    check("R5 queue drained", exp_q.size(), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 acc reset", {20'd0, acc_q}, 32'd0);
    check("R1 ext reset", {21'd0, ext_q}, 32'd0);
    check("R1 busy reset", {31'd0, busy}, 32'd0);
    check("R1 done reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    do_load(12'hA53);
    run_op(2'd2, 4'd0, 1'b0);      // R7
    do_load(12'h3C1);
    run_op(2'd0, 4'd3, 1'b0);      // R3
    run_op(2'd1, 4'd4, 1'b0);      // R4
    do_load(12'h8F0);
    run_op(2'd1, 4'd7, 1'b0);      // R4 with sign set
    run_op(2'd0, 4'd0, 1'b0);      // R6 left
    run_op(2'd1, 4'd0, 1'b0);      // R6 right
    run_op(2'd3, 4'd5, 1'b0);      // R8
    do_load(12'hFFF);
    run_op(2'd2, 4'd0, 1'b0);      // R7
    run_op(2'd3, 4'd0, 1'b0);      // R8 with all ones
    run_op(2'd1, 4'd1, 1'b0);      // R5 single step
    run_op(2'd0, 4'd15, 1'b0);     // R5 maximum count
    do_load(12'h9B7);
    run_op(2'd1, 4'd15, 1'b0);
    run_op(2'd0, 4'd5, 1'b1);      // R9 start and load during busy
    run_op(2'd1, 4'd6, 1'b1);      // R9
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule